// File: doc/BRIEF.md
# Divided-Input Clock Source Selector

This block is one output channel of a clock generator. It has three input clock domains, and it picks one of them to drive its output. Each input is seen as a stream of enable ticks in one fast system clock. Each input has its own programmable integer divider. The output tick stream is the divided tick stream of the selected input.

A reserved select code turns the output off. For each input, a running flag reports whether the output is currently being produced from that input. Software writes a new source and then polls the flag to learn when the switch has finished. Select, dividers and flags are reached through a plain register write/read port.

Control and status pins are plain level or pulse signals. There is no data stream, so there is no handshake and no back-pressure.

Top module: `clksrc_sel`

## Requirements
- R1: After reset the select register reads 3 (off), all three divider registers read 0, the status register reads 0, the running pins are 0 and `out_tick` is 0.
- R2: Register addresses are: 0 = select (code in bits [1:0]), 1 = status (running flags in bits [2:0], bit i for input i), 2/3/4 = divider of input 0/1/2 (bits [4:0]). Reads are combinational on `rd_addr`.
- R3: A divider field N divides its input by N+1. The first tick of an input after reset produces a divided tick. After that, every (N+1)-th tick produces one.
- R4: `out_tick` carries only the divided ticks of the selected input. Ticks on the other inputs have no effect on it.
- R5: While the select code is 3, `out_tick` stays 0.
- R6: A select write with bit 7 clear and a code of 3 is rejected. The select register keeps its old value and the running flags are not cleared.
- R7: A select write with bit 7 set (the off command) sets the select code to 3, whatever bits [1:0] hold.
- R8: A running flag i is 1 only while input i is selected and at least one divided tick of it has reached the output since the last accepted select write. At most one flag is set. A flag rises in the same cycle as that output tick.
- R9: Every accepted select write (a new code 0 to 2, or the off command) clears all running flags.
- R10: A divider register may be rewritten at any time. The new value takes effect only at the input's next terminal count, so the period in progress completes at full length.
- R11: A divided tick of the selected input shows on `out_tick` for exactly one cycle, in the cycle after the input tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | 3 | Enable tick of each input clock domain |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data |
| out_tick | output | 1 | Divided output tick of the selected input |
| running | output | 3 | Running flag per input |

## Verification
A divider counter that is out of phase shows up as a wrong number of output ticks within one divided period of the selected input. A wrong reload shows up at the first terminal count after a divider write. A select register that takes a rejected code shows on the next read of address 0. A running flag that is not cleared, or that is set for the wrong input, shows on the status read right after the select write, or right after the first output tick.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;
  localparam int N_IN   = 3;
  localparam int DIV_W  = 5;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int SEL_W  = $clog2(N_IN + 1);
  localparam int OFF_BIT = DATA_W - 1;

  typedef enum logic [ADDR_W-1:0] {
    RA_SEL  = 3'd0,
    RA_STAT = 3'd1,
    RA_DIV0 = 3'd2
  } reg_addr_e;
endpackage

// File: rtl/clksrc_div.sv
module clksrc_div #(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [DIV_W-1:0] div_val,
  output logic             pulse
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] act_q;
  logic             at_term;

  assign at_term = (cnt_q == act_q);
  assign pulse   = tick && at_term;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= '0;
    end else if (tick) begin
      if (at_term) begin
        cnt_q <= '0;
        act_q <= div_val;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R10: the running count never passes the divisor in use
  p_cnt_in_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= act_q);

  // R10: the divisor in use only moves at a terminal count
  p_reload_at_term_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && at_term) |=> $stable(act_q));
endmodule

// File: rtl/clksrc_regs.sv
module clksrc_regs
  import clksrc_pkg::*;
#(
  parameter int N     = N_IN,
  parameter int DW    = DIV_W,
  parameter int SW    = SEL_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [ADDR_W-1:0]     rd_addr,
  input  logic [N-1:0]          status,
  output logic [DATA_W-1:0]     rd_data,
  output logic [SW-1:0]         sel,
  output logic [N-1:0][DW-1:0]  divs,
  output logic                  sel_taken
);
  localparam logic [SW-1:0] OFF_CODE = SW'(N);

  logic [SW-1:0]        sel_q;
  logic [N-1:0][DW-1:0] div_q;
  logic                 sel_hit;
  logic                 off_cmd;
  logic                 code_ok;

  assign sel_hit   = wr_en && (wr_addr == RA_SEL);
  assign off_cmd   = wr_data[OFF_BIT];
  assign code_ok   = (wr_data[SW-1:0] < OFF_CODE);
  assign sel_taken = sel_hit && (off_cmd || code_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= OFF_CODE;
    end else if (sel_taken) begin
      sel_q <= off_cmd ? OFF_CODE : wr_data[SW-1:0];
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_divreg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        div_q[i] <= '0;
      end else if (wr_en && (wr_addr == ADDR_W'(RA_DIV0 + i))) begin
        div_q[i] <= wr_data[DW-1:0];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == RA_SEL) begin
      rd_data = DATA_W'(sel_q);
    end else if (rd_addr == RA_STAT) begin
      rd_data = DATA_W'(status);
    end else begin
      for (int i = 0; i < N; i++) begin
        if (rd_addr == ADDR_W'(RA_DIV0 + i)) rd_data = DATA_W'(div_q[i]);
      end
    end
  end

  assign sel  = sel_q;
  assign divs = div_q;

  // R6: an out-of-range code without the off command leaves the select alone
  p_reject_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_hit && !off_cmd && !code_ok) |=> $stable(sel_q));

  // R7: the off command always lands on the off code
  p_off_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_hit && off_cmd) |=> (sel_q == OFF_CODE));
endmodule

// File: rtl/clksrc_sel.sv
module clksrc_sel
  import clksrc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN-1:0]   src_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              out_tick,
  output logic [N_IN-1:0]   running
);
  localparam logic [SEL_W-1:0] OFF_CODE = SEL_W'(N_IN);

  logic [SEL_W-1:0]            sel;
  logic [N_IN-1:0][DIV_W-1:0]  divs;
  logic                        sel_taken;
  logic [N_IN-1:0]             div_pulse;
  logic [N_IN-1:0]             pick;
  logic                        out_q;
  logic [N_IN-1:0]             run_q;

  clksrc_regs #(.N(N_IN), .DW(DIV_W), .SW(SEL_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .status   (run_q),
    .rd_data  (rd_data),
    .sel      (sel),
    .divs     (divs),
    .sel_taken(sel_taken)
  );

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    clksrc_div #(.DIV_W(DIV_W)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (src_tick[i]),
      .div_val(divs[i]),
      .pulse  (div_pulse[i])
    );
    assign pick[i] = div_pulse[i] && (sel == SEL_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      run_q <= '0;
    end else begin
      out_q <= |pick;
      if (sel_taken) run_q <= '0;
      else           run_q <= run_q | pick;
    end
  end

  assign out_tick = out_q;
  assign running  = run_q;

  // R5: the off code keeps the output quiet
  p_off_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == OFF_CODE) |=> !out_tick);

  // R8: at most one running flag
  p_run_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(running));

  // R8: a set flag belongs to the selected input
  p_run_matches_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (running != '0) |-> (sel != OFF_CODE));

  // R9: an accepted select write drops every flag
  p_switch_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_taken |=> (running == '0));

  // R11: output ticks last one cycle unless the source ticks back to back
  p_out_needs_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (src_tick == '0) |=> !out_tick);
endmodule

// File: tb/clksrc_sel_tb.sv
`timescale 1ns/1ps
module clksrc_sel_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] src_tick = '0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       out_tick;
  logic [2:0] running;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  clksrc_sel u_dut (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .out_tick(out_tick), .running(running)
  );

  // vector: {sel[1:0], off, div[4:0], ticks[7:0], expected pulses[7:0]}
  localparam logic [23:0] VEC [7] = '{
    {2'd0, 1'b0, 5'd0,  8'd5,  8'd5},
    {2'd1, 1'b0, 5'd2,  8'd7,  8'd3},
    {2'd2, 1'b0, 5'd4,  8'd11, 8'd3},
    {2'd0, 1'b0, 5'd31, 8'd40, 8'd2},
    {2'd0, 1'b1, 5'd3,  8'd8,  8'd0},
    {2'd2, 1'b0, 5'd1,  8'd6,  8'd3},
    {2'd1, 1'b0, 5'd7,  8'd17, 8'd3}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    src_tick = '0;
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  // one tick on the masked inputs, then a quiet cycle; returns out_tick seen
  task automatic tick(input logic [2:0] m, output int o);
    @(negedge clk);
    src_tick = m;
    @(negedge clk);
    src_tick = '0;
    o = int'(out_tick);
    @(negedge clk);
  endtask

  initial begin
    int v, o, cnt;
    // R1, R2: reset state through the read port
    do_reset();
    rd(3'd0, v); chk("R1 sel after reset", v, 3);
    rd(3'd1, v); chk("R1 status after reset", v, 0);
    for (int i = 0; i < 3; i++) begin
      rd(3'(2 + i), v); chk("R1 divider after reset", v, 0);
    end
    chk("R1 out_tick after reset", int'(out_tick), 0);
    chk("R1 running pins after reset", int'(running), 0);

    // R3, R4, R5: table walk
    for (int k = 0; k < 7; k++) begin
      logic [1:0] s; logic off; logic [4:0] d; int nt, ex;
      s = VEC[k][23:22]; off = VEC[k][21]; d = VEC[k][20:16];
      nt = int'(VEC[k][15:8]); ex = int'(VEC[k][7:0]);
      do_reset();
      for (int i = 0; i < 3; i++) wr(3'(2 + i), {3'b0, d});
      rd(3'(2 + s), v); chk("R2 divider readback", v, int'(d));
      wr(3'd0, {off, 5'b0, s});
      cnt = 0;
      for (int t = 0; t < nt; t++) begin
        tick(3'b111, o);
        cnt += o;
      end
      chk(off ? "R5 off output count" : "R3 divided output count", cnt, ex);
      rd(3'd1, v);
      chk("R8 status after table run", v, ex > 0 ? (1 << s) : 0);
    end

    // R8, R9, R4, R11: switching
    do_reset();
    wr(3'd0, 8'd1);
    rd(3'd0, v); chk("R2 sel readback", v, 1);
    rd(3'd1, v); chk("R8 not running before first tick", v, 0);
    @(negedge clk); src_tick = 3'b010;
    @(negedge clk); src_tick = 3'b000;
    chk("R11 out one cycle after tick", int'(out_tick), 1);
    chk("R8 running rises with output", int'(running), 3'b010);
    @(negedge clk);
    chk("R11 out lasts one cycle", int'(out_tick), 0);
    tick(3'b001, o); chk("R4 unselected input ignored", o, 0);
    wr(3'd0, 8'd3);
    rd(3'd0, v); chk("R6 code 3 rejected", v, 1);
    rd(3'd1, v); chk("R6 flags kept on reject", v, 3'b010);
    wr(3'd0, 8'd2);
    rd(3'd1, v); chk("R9 switch clears flags", v, 0);
    tick(3'b010, o); chk("R4 old source stopped", o, 0);
    rd(3'd1, v); chk("R8 old input flag stays 0", v, 0);
    tick(3'b100, o); chk("R3 new source first tick", o, 1);
    rd(3'd1, v); chk("R8 new input running", v, 3'b100);

    // R7, R5: off command
    wr(3'd0, 8'h81);
    rd(3'd0, v); chk("R7 off command sets code 3", v, 3);
    rd(3'd1, v); chk("R9 off clears flags", v, 0);
    tick(3'b111, o); chk("R5 off keeps output low", o, 0);

    // R10: divider rewrite mid-period
    do_reset();
    wr(3'd0, 8'd0);
    wr(3'd2, 8'd3);
    tick(3'b001, o); chk("R10 first tick reloads", o, 1);
    tick(3'b001, o); chk("R10 count 1", o, 0);
    tick(3'b001, o); chk("R10 count 2", o, 0);
    wr(3'd2, 8'd1);
    tick(3'b001, o); chk("R10 old period continues", o, 0);
    tick(3'b001, o); chk("R10 old period ends", o, 1);
    tick(3'b001, o); chk("R10 new period count", o, 0);
    tick(3'b001, o); chk("R10 new period ends", o, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule